// File: doc/BRIEF.md
# Sector Erase Accumulation Window Timer

This block sits inside a sectored flash erase engine and decides when an erase actually begins. When a sector erase command arrives while the engine is idle, the block marks that sector in a selection mask and opens a timed window. Further sector erase commands that arrive while the window is open add their sectors to the mask. Each accepted command also restarts the window from its full length. When the window runs out with no new command, the block emits a one-cycle start pulse that carries the collected mask. It then holds the engine busy until the erase engine reports completion.

A status output tells the host whether more sectors can still be added. It reads 0 while the window is open and 1 once the sector erase has begun. While the erase runs, every command is ignored except suspend, which raises a suspend request. A chip erase command from idle skips the window and starts at once with every sector selected. The status bit stays 0 throughout a chip erase. The window length is set in microseconds and is converted to clock cycles from the clock frequency parameter.

Top module: `sector_erase_window`

## Requirements
- R1: While reset is asserted and after it is released, busy, window_status, erase_start, suspend_req and every erase_mask bit read 0.
- R2: A sector erase command from idle with a sector index below NUM_SECTORS sets bit `index` of erase_mask and raises busy one cycle later. window_status reads 0 at that point.
- R3: The window length is WINDOW_CYC = (CLK_FREQ_HZ/1000)*WINDOW_US/1000 cycles. The window stays open for exactly that many cycles after the last accepted sector command, with busy=1, window_status=0 and erase_start=0 throughout.
- R4: A valid sector erase command while the window is open ORs its bit into the mask and restarts the full window. This includes a command in the window's last cycle. Selecting a sector that is already in the mask has no effect beyond the restart.
- R5: When the window expires, erase_start is high for exactly one cycle with erase_mask holding the collected selection. window_status goes to 1 in that same cycle and stays 1 until erase_done.
- R6: While an erase runs, sector erase and chip erase commands are ignored. erase_mask stays the same and no new erase_start occurs.
- R7: suspend_cmd during an erase sets suspend_req from the next cycle until erase_done. suspend_cmd while idle or while the window is open is ignored.
- R8: erase_done during an erase returns the block to idle on the next cycle: busy=0, erase_mask=0, window_status=0, suspend_req=0.
- R9: A chip erase command from idle gives erase_start one cycle later with all NUM_SECTORS mask bits set and busy=1. window_status stays 0 for the whole chip erase.
- R10: A chip erase command while the window is open is ignored. The window keeps its timing and its mask.
- R11: If a chip erase command and a sector erase command arrive from idle in the same cycle, the chip erase wins.
- R12: A sector index of NUM_SECTORS or above is ignored. From idle it opens no window. Inside a window it neither sets a bit nor restarts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_erase_cmd | input | 1 | Sector erase command strobe |
| sec_idx | input | SECTOR_IDX_W | Sector index for sec_erase_cmd |
| chip_erase_cmd | input | 1 | Chip erase command strobe |
| suspend_cmd | input | 1 | Erase suspend command strobe |
| erase_done | input | 1 | Erase engine finished |
| erase_start | output | 1 | One-cycle pulse that starts the erase |
| erase_mask | output | NUM_SECTORS | Selected sectors, one bit per sector |
| window_status | output | 1 | 0 while the window is open, 1 while a sector erase runs |
| busy | output | 1 | Window open or erase running |
| suspend_req | output | 1 | Suspend requested during the erase |

## Verification
Some rules are checked by the assertions on every cycle. The start pulse lasts a single cycle. The status bit only rises together with the start pulse and is never high while idle. The mask stays frozen while a sector erase runs. Completion clears all state, and a suspend request never exists outside an erase. Other behaviour can only be shown by the bench's scenarios. These are the exact window length, the restart of the window at every offset including its last cycle, and the OR-ing of sectors. They also cover the ignore rules for out-of-range indices and for chip erase inside the window, and the priority of chip erase from idle.

// File: rtl/sew_pkg.sv
package sew_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2
  } sew_state_e;

  // Converts a window length in microseconds into clock cycles.
  function automatic int unsigned window_cycles(input int unsigned clk_hz,
                                                input int unsigned win_us);
    int unsigned cyc;
    cyc = (clk_hz / 1000) * win_us / 1000;
    if (cyc == 0) cyc = 1;
    return cyc;
  endfunction

endpackage

// File: rtl/sew_window_timer.sv
module sew_window_timer #(
  parameter int unsigned WINDOW_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int unsigned CNT_W = $clog2(WINDOW_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WINDOW_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = RELOAD;
      cnt_en = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sew_sector_mask.sv
module sew_sector_mask #(
  parameter int unsigned NUM_SECTORS  = 16,
  parameter int unsigned SECTOR_IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    fill,
  input  logic                    set_en,
  input  logic [SECTOR_IDX_W-1:0] set_idx,
  output logic                    idx_ok,
  output logic [NUM_SECTORS-1:0]  mask
);
  localparam int unsigned LIMIT_W = SECTOR_IDX_W + 1;
  localparam logic [LIMIT_W-1:0] LIMIT = LIMIT_W'(NUM_SECTORS);

  assign idx_ok = ({1'b0, set_idx} < LIMIT);

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_bit
    logic bit_q, bit_d, hit;
    assign hit = set_en && idx_ok && (set_idx == SECTOR_IDX_W'(g));
    always_comb begin
      bit_d = bit_q;
      if (clr)       bit_d = 1'b0;
      else if (fill) bit_d = 1'b1;
      else if (hit)  bit_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  bit_q <= 1'b0;
      else if (clr || fill || hit) bit_q <= bit_d;
    end
    assign mask[g] = bit_q;
  end

endmodule

// File: rtl/sew_ctrl.sv
module sew_ctrl
  import sew_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sec_cmd,
  input  logic idx_ok,
  input  logic chip_cmd,
  input  logic suspend_cmd,
  input  logic erase_done,
  input  logic expired,
  output logic timer_load,
  output logic timer_run,
  output logic mask_clr,
  output logic mask_fill,
  output logic mask_set,
  output logic erase_start,
  output logic window_status,
  output logic busy,
  output logic suspend_req,
  output logic erasing
);
  sew_state_e state_q, state_d;
  logic       chip_q, chip_d;
  logic       start_q, start_d;
  logic       susp_q, susp_d;
  logic       accept_sec;

  always_comb begin
    state_d    = state_q;
    chip_d     = chip_q;
    start_d    = 1'b0;
    susp_d     = susp_q;
    timer_load = 1'b0;
    timer_run  = 1'b0;
    mask_clr   = 1'b0;
    mask_fill  = 1'b0;
    mask_set   = 1'b0;
    accept_sec = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (chip_cmd) begin
          state_d   = ST_ERASE;
          chip_d    = 1'b1;
          start_d   = 1'b1;
          mask_fill = 1'b1;
        end else if (sec_cmd && idx_ok) begin
          accept_sec = 1'b1;
          state_d    = ST_WINDOW;
        end
      end
      ST_WINDOW: begin
        if (sec_cmd && idx_ok) begin
          accept_sec = 1'b1;
        end else if (expired) begin
          state_d = ST_ERASE;
          chip_d  = 1'b0;
          start_d = 1'b1;
        end else begin
          timer_run = 1'b1;
        end
      end
      ST_ERASE: begin
        if (erase_done) begin
          state_d  = ST_IDLE;
          chip_d   = 1'b0;
          susp_d   = 1'b0;
          mask_clr = 1'b1;
        end else if (suspend_cmd) begin
          susp_d = 1'b1;
        end
      end
      default: begin
        state_d  = ST_IDLE;
        mask_clr = 1'b1;
      end
    endcase
    if (accept_sec) begin
      timer_load = 1'b1;
      mask_set   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chip_q  <= 1'b0;
      start_q <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      chip_q  <= chip_d;
      start_q <= start_d;
      susp_q  <= susp_d;
    end
  end

  assign erasing       = (state_q == ST_ERASE);
  assign busy          = (state_q != ST_IDLE);
  assign window_status = erasing && !chip_q;
  assign erase_start   = start_q;
  assign suspend_req   = susp_q;

endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window
  import sew_pkg::*;
#(
  parameter int unsigned NUM_SECTORS  = 16,
  parameter int unsigned SECTOR_IDX_W = 4,
  parameter int unsigned CLK_FREQ_HZ  = 100_000_000,
  parameter int unsigned WINDOW_US    = 50
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sec_erase_cmd,
  input  logic [SECTOR_IDX_W-1:0] sec_idx,
  input  logic                    chip_erase_cmd,
  input  logic                    suspend_cmd,
  input  logic                    erase_done,
  output logic                    erase_start,
  output logic [NUM_SECTORS-1:0]  erase_mask,
  output logic                    window_status,
  output logic                    busy,
  output logic                    suspend_req
);
  localparam int unsigned WINDOW_CYC = window_cycles(CLK_FREQ_HZ, WINDOW_US);

  logic rst_meta_q, rst_sync_n;
  logic timer_load, timer_run, expired;
  logic mask_clr, mask_fill, mask_set, idx_ok;
  logic erasing;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  sew_window_timer #(
    .WINDOW_CYC(WINDOW_CYC)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (timer_load),
    .run     (timer_run),
    .expired (expired)
  );

  sew_sector_mask #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECTOR_IDX_W(SECTOR_IDX_W)
  ) i_mask (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (mask_clr),
    .fill    (mask_fill),
    .set_en  (mask_set),
    .set_idx (sec_idx),
    .idx_ok  (idx_ok),
    .mask    (erase_mask)
  );

  sew_ctrl i_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .sec_cmd       (sec_erase_cmd),
    .idx_ok        (idx_ok),
    .chip_cmd      (chip_erase_cmd),
    .suspend_cmd   (suspend_cmd),
    .erase_done    (erase_done),
    .expired       (expired),
    .timer_load    (timer_load),
    .timer_run     (timer_run),
    .mask_clr      (mask_clr),
    .mask_fill     (mask_fill),
    .mask_set      (mask_set),
    .erase_start   (erase_start),
    .window_status (window_status),
    .busy          (busy),
    .suspend_req   (suspend_req),
    .erasing       (erasing)
  );

endmodule

// File: rtl/sew_checker.sv
module sew_checker #(
  parameter int unsigned NUM_SECTORS = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   erase_start,
  input logic [NUM_SECTORS-1:0] erase_mask,
  input logic                   window_status,
  input logic                   busy,
  input logic                   suspend_req,
  input logic                   erase_done,
  input logic                   erasing
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start); // R5

  AST_STATUS_RISES_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_status) |-> erase_start); // R5

  AST_STATUS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    window_status |-> busy); // R5

  AST_MASK_FROZEN_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (window_status && $past(window_status)) |-> $stable(erase_mask)); // R6

  AST_DONE_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && erase_done) |=> (!busy && !window_status && !suspend_req && (erase_mask == '0))); // R8

  AST_SUSPEND_ONLY_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> erasing); // R7

endmodule

bind sector_erase_window sew_checker #(
  .NUM_SECTORS(NUM_SECTORS)
) i_sew_checker (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .erase_start   (erase_start),
  .erase_mask    (erase_mask),
  .window_status (window_status),
  .busy          (busy),
  .suspend_req   (suspend_req),
  .erase_done    (erase_done),
  .erasing       (erasing)
);

// File: tb/test_sector_erase_window.sv
module test_sector_erase_window;
  localparam int unsigned N      = 6;
  localparam int unsigned IW     = 3;
  localparam int unsigned HZ     = 1_000_000;
  localparam int unsigned US     = 20;
  localparam int unsigned W      = HZ / 1_000_000 * US;  // 20 cycles
  localparam time         CLK_PERIOD = 10ns;
  localparam logic [N-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sec_erase_cmd, chip_erase_cmd, suspend_cmd, erase_done;
  logic [IW-1:0] sec_idx;
  logic          erase_start, window_status, busy, suspend_req;
  logic [N-1:0]  erase_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_erase_window #(
    .NUM_SECTORS(N), .SECTOR_IDX_W(IW), .CLK_FREQ_HZ(HZ), .WINDOW_US(US)
  ) i_sector_erase_window (
    .clk(clk), .rst_n(rst_n), .sec_erase_cmd(sec_erase_cmd), .sec_idx(sec_idx),
    .chip_erase_cmd(chip_erase_cmd), .suspend_cmd(suspend_cmd), .erase_done(erase_done),
    .erase_start(erase_start), .erase_mask(erase_mask), .window_status(window_status),
    .busy(busy), .suspend_req(suspend_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic state_chk(input string req, input logic b, input logic st,
                           input logic s, input logic [N-1:0] m, input logic sr);
    chk(req, "busy", 32'(busy), 32'(b));
    chk(req, "window_status", 32'(window_status), 32'(st));
    chk(req, "erase_start", 32'(erase_start), 32'(s));
    chk(req, "erase_mask", 32'(erase_mask), 32'(m));
    chk(req, "suspend_req", 32'(suspend_req), 32'(sr));
  endtask

  // All stimulus tasks start and end on a falling edge.
  task automatic sector(input int idx);
    sec_erase_cmd = 1'b1; sec_idx = IW'(idx);
    @(negedge clk);
    sec_erase_cmd = 1'b0; sec_idx = '0;
  endtask

  task automatic chip();
    chip_erase_cmd = 1'b1;
    @(negedge clk);
    chip_erase_cmd = 1'b0;
  endtask

  task automatic done();
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
    state_chk("R8", 1'b0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  // Called right after the last accepted sector command was latched.
  task automatic run_window(input logic [N-1:0] m, input string req);
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      if (k < W) begin
        chk(req, "window open busy", 32'(busy), 32'd1);
        chk(req, "window open status", 32'(window_status), 32'd0);
        chk(req, "window open start", 32'(erase_start), 32'd0);
      end else begin
        state_chk(req, 1'b1, 1'b1, 1'b1, m, 1'b0);
      end
    end
    @(negedge clk);
    chk("R5", "start is one cycle", 32'(erase_start), 32'd0);
    chk("R5", "status held", 32'(window_status), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    sec_erase_cmd = 1'b0; chip_erase_cmd = 1'b0; suspend_cmd = 1'b0;
    erase_done = 1'b0; sec_idx = '0;
    repeat (3) @(negedge clk);
    state_chk("R1", 1'b0, 1'b0, 1'b0, '0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    state_chk("R1", 1'b0, 1'b0, 1'b0, '0, 1'b0);

    // R2 R3 R5: one sector each, every valid index
    for (int s = 0; s < int'(N); s++) begin
      sector(s);
      state_chk("R2", 1'b1, 1'b0, 1'b0, N'(1) << s, 1'b0);
      run_window(N'(1) << s, "R3");
      done();
    end

    // R4: second sector at every offset inside the window, last cycle included
    for (int d = 0; d < int'(W); d++) begin
      int s1 = d % N;
      int s2 = (d + 2) % N;
      sector(s1);
      repeat (d) @(negedge clk);
      sector(s2);
      chk("R4", "mask ORed", 32'(erase_mask), 32'((N'(1) << s1) | (N'(1) << s2)));
      run_window((N'(1) << s1) | (N'(1) << s2), "R4");
      done();
    end

    // R4: repeated sector just restarts
    sector(3);
    repeat (5) @(negedge clk);
    sector(3);
    run_window(N'(1) << 3, "R4");
    done();

    // R12: out of range from idle and inside a window
    sector(7);
    state_chk("R12", 1'b0, 1'b0, 1'b0, '0, 1'b0);
    sector(6);
    state_chk("R12", 1'b0, 1'b0, 1'b0, '0, 1'b0);
    sector(1);
    repeat (4) @(negedge clk);
    sector(6);
    chk("R12", "no bit set", 32'(erase_mask), 32'(N'(1) << 1));
    repeat (W - 6) @(negedge clk);
    chk("R12", "no restart, still open", 32'(erase_start), 32'd0);
    @(negedge clk);
    chk("R12", "expiry at original time", 32'(erase_start), 32'd1);
    chk("R12", "mask", 32'(erase_mask), 32'(N'(1) << 1));
    done();

    // R10 R7: chip erase and suspend inside the window are ignored
    sector(2);
    repeat (3) @(negedge clk);
    chip();
    chk("R10", "no start", 32'(erase_start), 32'd0);
    chk("R10", "mask kept", 32'(erase_mask), 32'(N'(1) << 2));
    suspend_cmd = 1'b1;
    @(negedge clk);
    suspend_cmd = 1'b0;
    chk("R7", "no suspend in window", 32'(suspend_req), 32'd0);
    repeat (W - 6) @(negedge clk);
    chk("R10", "window timing kept", 32'(erase_start), 32'd0);
    @(negedge clk);
    state_chk("R10", 1'b1, 1'b1, 1'b1, N'(1) << 2, 1'b0);

    // R6: commands during the erase are ignored
    @(negedge clk);
    sector(4);
    state_chk("R6", 1'b1, 1'b1, 1'b0, N'(1) << 2, 1'b0);
    chip();
    state_chk("R6", 1'b1, 1'b1, 1'b0, N'(1) << 2, 1'b0);
    repeat (W + 2) @(negedge clk);
    state_chk("R6", 1'b1, 1'b1, 1'b0, N'(1) << 2, 1'b0);

    // R7: suspend during the erase, held until done
    suspend_cmd = 1'b1;
    @(negedge clk);
    suspend_cmd = 1'b0;
    chk("R7", "suspend_req set", 32'(suspend_req), 32'd1);
    repeat (4) @(negedge clk);
    chk("R7", "suspend_req held", 32'(suspend_req), 32'd1);
    done();

    // R7 R8: suspend and done while idle are ignored
    suspend_cmd = 1'b1; erase_done = 1'b1;
    @(negedge clk);
    suspend_cmd = 1'b0; erase_done = 1'b0;
    state_chk("R7", 1'b0, 1'b0, 1'b0, '0, 1'b0);

    // R9: chip erase from idle
    chip();
    state_chk("R9", 1'b1, 1'b0, 1'b1, ALL, 1'b0);
    repeat (W + 3) begin
      @(negedge clk);
      state_chk("R9", 1'b1, 1'b0, 1'b0, ALL, 1'b0);
    end
    done();

    // R11: chip and sector in the same cycle
    chip_erase_cmd = 1'b1; sec_erase_cmd = 1'b1; sec_idx = IW'(1);
    @(negedge clk);
    chip_erase_cmd = 1'b0; sec_erase_cmd = 1'b0; sec_idx = '0;
    state_chk("R11", 1'b1, 1'b0, 1'b1, ALL, 1'b0);
    done();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule